// File: doc/BRIEF.md
# Memory-Speed Bus Cycle Timer

This block times each access on a processor bus in master clocks. When an access starts, the block reads a two-bit speed class and a read/write flag. It then runs the access through a hold phase and, for reads only, a wait phase. The length of each phase depends on the speed class and the direction.

For a read, the hold phase lasts 2, 4 or 8 clocks, and a 4-clock wait phase follows it. A write is one hold phase that lasts the whole access. Both directions take 6, 8 or 12 clocks in total for the same class.

A peripheral that takes its data from the access is told when to latch it. For a read this is the last clock of the hold phase. For a write it is the final clock of the access. The block also gives a busy flag, a wait-phase indicator and a one-clock completion pulse. Address decoding and the data path belong to other blocks.

The control is a three-state machine:
- States: IDLE (no access), HOLD (hold phase), WAIT (read wait phase).
- Transitions: IDLE→HOLD (start accepted), HOLD→HOLD and WAIT→WAIT (count running), HOLD→WAIT (read hold count reaches zero), HOLD→IDLE (write count reaches zero), WAIT→IDLE (wait count reaches zero).

A down-counter is loaded from a table that the speed class and the direction index. It is loaded once on entry to HOLD and once on entry to WAIT.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset, `busy`, `in_wait`, `latch_stb` and `done` are all 0, and they stay 0 while `start` is low.
- R2: Speed class encoding is 0 = fast, 1 = slow, 2 = extra-slow, and 3 is also treated as extra-slow. A read holds for 2, 4 or 8 clocks and then waits for 4 clocks, so it lasts 6, 8 or 12 clocks.
- R3: A write has no wait phase. `in_wait` stays 0 for the whole write, which lasts 6, 8 or 12 clocks for classes fast, slow and extra-slow (3 also extra-slow).
- R4: The clock edge that accepts `start` is counted as cycle 0. `busy` is 1 in cycles 1 through T, where T is the access length, and it is 0 in cycle T+1.
- R5: For a read with hold length H, `in_wait` is 1 exactly in cycles H+1 through T.
- R6: `latch_stb` is 1 for exactly one cycle per access. That cycle is H for a read and T for a write.
- R7: `done` is 1 for exactly one cycle per access, in cycle T.
- R8: `start` is ignored in every clock in which `busy` is 1, including the cycle in which `done` is 1. The class and direction are captured when the access is accepted, so changing them during the access has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an access (taken only while idle) |
| is_write | input | 1 | 1 = write access, 0 = read access |
| speed | input | 2 | Speed class: 0 fast, 1 slow, 2/3 extra-slow |
| in_wait | output | 1 | 1 during the wait phase of a read |
| busy | output | 1 | 1 while an access is in progress |
| latch_stb | output | 1 | One-clock strobe telling the peripheral to latch |
| done | output | 1 | One-clock pulse on the final clock of the access |

## Verification
All outputs are decoded from registered state. The state after the accepting edge is therefore first visible in cycle 1, the cycle after that edge.

The bench drives `start` at a falling edge. It then samples every output at each following falling edge for cycles 1 through T+1, and compares each sample with the value computed from H and T for that class and direction. The latch strobe is expected at cycle H or T, done at T, and the idle state at T+1.

All eight class and direction pairs are swept. The sweep is repeated with `start` held high and the class and direction flipped during the access. This shows that the timing of the ongoing access is unchanged, and that the done-cycle edge does not start a new access.

// File: rtl/bct_pkg.sv
package bct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_WAIT = 2'd2
    } bct_state_t;

    localparam logic [1:0] SPD_FAST  = 2'd0;
    localparam logic [1:0] SPD_SLOW  = 2'd1;
    localparam logic [1:0] SPD_XSLOW = 2'd2;
    localparam int unsigned NUM_CLASSES = 4;

endpackage

// File: rtl/bct_len_table.sv
module bct_len_table #(
    parameter int unsigned FAST_HOLD  = 2,
    parameter int unsigned SLOW_HOLD  = 4,
    parameter int unsigned XSLOW_HOLD = 8,
    parameter int unsigned READ_WAIT  = 4,
    parameter int unsigned CW         = 4
) (
    input  logic [1:0]    cls,
    input  logic          wr,
    output logic [CW-1:0] hold_m1,
    output logic [CW-1:0] wait_m1
);
    import bct_pkg::*;

    logic [CW-1:0] rd_hold [NUM_CLASSES];
    logic [CW-1:0] wr_hold [NUM_CLASSES];

    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_cls
        localparam int unsigned HL = (i == 0) ? FAST_HOLD :
                                     (i == 1) ? SLOW_HOLD : XSLOW_HOLD;
        assign rd_hold[i] = CW'(HL - 1);
        assign wr_hold[i] = CW'(HL + READ_WAIT - 1);
    end

    always_comb begin
        hold_m1 = wr ? wr_hold[cls] : rd_hold[cls];
        wait_m1 = CW'(READ_WAIT - 1);
    end

endmodule

// File: rtl/bct_downcount.sv
module bct_downcount #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/bct_ctrl.sv
module bct_ctrl #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_write,
    input  logic [1:0]    speed,
    input  logic          cnt_zero,
    input  logic [CW-1:0] hold_m1,
    input  logic [CW-1:0] wait_m1,
    output logic [1:0]    tbl_cls,
    output logic          tbl_wr,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          in_wait,
    output logic          busy,
    output logic          latch_stb,
    output logic          done
);
    import bct_pkg::*;

    bct_state_t state, state_nx;
    logic [1:0] cap_cls;
    logic       cap_wr;
    logic       accept;

    assign accept = (state == ST_IDLE) && start;

    // table lookup uses live inputs while idle, captured ones afterwards
    assign tbl_cls = (state == ST_IDLE) ? speed    : cap_cls;
    assign tbl_wr  = (state == ST_IDLE) ? is_write : cap_wr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_HOLD;
            ST_HOLD: if (cnt_zero) state_nx = cap_wr ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (cnt_zero) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cap_cls <= SPD_FAST;
            cap_wr  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cap_cls <= speed;
                cap_wr  <= is_write;
            end
        end
    end

    always_comb begin
        cnt_load  = 1'b0;
        cnt_val   = hold_m1;
        in_wait   = 1'b0;
        busy      = 1'b0;
        latch_stb = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_load = start;
                cnt_val  = hold_m1;
            end
            ST_HOLD: begin
                busy      = 1'b1;
                latch_stb = cnt_zero;
                done      = cnt_zero && cap_wr;
                cnt_load  = cnt_zero && !cap_wr;
                cnt_val   = wait_m1;
            end
            ST_WAIT: begin
                busy    = 1'b1;
                in_wait = 1'b1;
                done    = cnt_zero;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
    parameter int unsigned FAST_HOLD  = 2,
    parameter int unsigned SLOW_HOLD  = 4,
    parameter int unsigned XSLOW_HOLD = 8,
    parameter int unsigned READ_WAIT  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_write,
    input  logic [1:0] speed,
    output logic       in_wait,
    output logic       busy,
    output logic       latch_stb,
    output logic       done
);
    localparam int unsigned MAX_LEN = XSLOW_HOLD + READ_WAIT;
    localparam int unsigned CW      = $clog2(MAX_LEN + 1);

    logic [1:0]    tbl_cls;
    logic          tbl_wr;
    logic [CW-1:0] hold_m1;
    logic [CW-1:0] wait_m1;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;

    bct_len_table #(
        .FAST_HOLD (FAST_HOLD),
        .SLOW_HOLD (SLOW_HOLD),
        .XSLOW_HOLD(XSLOW_HOLD),
        .READ_WAIT (READ_WAIT),
        .CW        (CW)
    ) u_tbl (
        .cls    (tbl_cls),
        .wr     (tbl_wr),
        .hold_m1(hold_m1),
        .wait_m1(wait_m1)
    );

    bct_downcount #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .zero    (cnt_zero)
    );

    bct_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (is_write),
        .speed    (speed),
        .cnt_zero (cnt_zero),
        .hold_m1  (hold_m1),
        .wait_m1  (wait_m1),
        .tbl_cls  (tbl_cls),
        .tbl_wr   (tbl_wr),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .in_wait  (in_wait),
        .busy     (busy),
        .latch_stb(latch_stb),
        .done     (done)
    );

endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
    parameter int unsigned FAST_HOLD  = 2,
    parameter int unsigned SLOW_HOLD  = 4,
    parameter int unsigned XSLOW_HOLD = 8,
    parameter int unsigned READ_WAIT  = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       is_write,
    input logic [1:0] speed,
    input logic       in_wait,
    input logic       busy,
    input logic       latch_stb,
    input logic       done
);
    logic [7:0] cyc;
    logic [1:0] c_cls;
    logic       c_wr;
    logic [7:0] exp_hold;
    logic [7:0] exp_total;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc   <= '0;
            c_cls <= 2'd0;
            c_wr  <= 1'b0;
        end else if (start && !busy) begin
            cyc   <= 8'd1;
            c_cls <= speed;
            c_wr  <= is_write;
        end else if (busy) begin
            cyc <= cyc + 8'd1;
        end
    end

    assign exp_hold  = (c_cls == 2'd0) ? 8'(FAST_HOLD) :
                       (c_cls == 2'd1) ? 8'(SLOW_HOLD) : 8'(XSLOW_HOLD);
    assign exp_total = exp_hold + 8'(READ_WAIT);

    assert_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == exp_total));

    assert_write_nowait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && c_wr) |-> !in_wait);

    assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_wait_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> busy);

    assert_latch_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> (busy && (cyc == (c_wr ? exp_total : exp_hold))));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind bus_cycle_timer bct_checker #(
    .FAST_HOLD (FAST_HOLD),
    .SLOW_HOLD (SLOW_HOLD),
    .XSLOW_HOLD(XSLOW_HOLD),
    .READ_WAIT (READ_WAIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_write (is_write),
    .speed    (speed),
    .in_wait  (in_wait),
    .busy     (busy),
    .latch_stb(latch_stb),
    .done     (done)
);

// File: tb/sim_bus_cycle_timer.sv
module sim_bus_cycle_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       is_write = 1'b0;
    logic [1:0] speed = 2'd0;
    logic       in_wait, busy, latch_stb, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_cycle_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (is_write),
        .speed    (speed),
        .in_wait  (in_wait),
        .busy     (busy),
        .latch_stb(latch_stb),
        .done     (done)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%0b exp=%0b", req, what, got, exp);
        end
    endtask

    task automatic run_access(input logic [1:0] cls, input logic wr, input logic keep);
        int h;
        int t;
        h = (cls == 2'd0) ? 2 : (cls == 2'd1) ? 4 : 8;
        t = h + 4;
        start = 1'b1; speed = cls; is_write = wr;
        @(posedge clk); @(negedge clk);
        for (int k = 1; k <= t + 1; k++) begin
            if (k == 1) begin
                if (keep) begin speed = ~cls; is_write = ~wr; end
                else start = 1'b0;
            end
            if (k == t + 1) start = 1'b0;
            chk("R4", $sformatf("busy cls%0d wr%0b k%0d", cls, wr, k), busy, k <= t);
            if (wr)
                chk("R3", $sformatf("in_wait cls%0d k%0d", cls, k), in_wait, 1'b0);
            else
                chk("R5", $sformatf("in_wait cls%0d k%0d", cls, k), in_wait, (k > h) && (k <= t));
            chk("R6", $sformatf("latch cls%0d wr%0b k%0d", cls, wr, k), latch_stb, k == (wr ? t : h));
            chk(keep ? "R8" : "R7", $sformatf("done cls%0d wr%0b k%0d", cls, wr, k), done, k == t);
            if (k <= t) begin @(posedge clk); @(negedge clk); end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 1'b0);
        chk("R1", "done in reset", done, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R1", "idle busy", busy, 1'b0);
            chk("R1", "idle in_wait", in_wait, 1'b0);
            chk("R1", "idle latch", latch_stb, 1'b0);
            chk("R1", "idle done", done, 1'b0);
        end
        // R2 sweep of all classes, both directions, back to back
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 2; w++)
                run_access(2'(c), 1'(w), 1'b0);
        // R8 start held high with class/direction flipped mid-access
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 2; w++)
                run_access(2'(c), 1'(w), 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R1", "final idle", busy, 1'b0);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule